// File: doc/BRIEF.md
# 64-bit Event Timer with Register Access

This block is a 64-bit up-counting event timer sitting on a plain 32-bit register bus: an address, a write strobe, write data and combinational read data. Software loads a 64-bit period and, when needed, a 64-bit starting count, each as a pair of 32-bit words. A two-bit mode field in the control word picks between stopped, single-shot and repeating operation. A separate release word holds each counter half in reset until software sets its bit.

When the running count equals the period, the counter returns to zero on the next clock and a sticky status flag is set. The interrupt output is that flag qualified by an enable bit, and software clears the flag by writing a one to it. In single-shot operation the hardware clears the mode field after the match, so the timer stops at zero. In repeating operation it keeps counting, and a period value P gives one match every P+1 clocks.

Top module: `evt_timer64`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0.
- R2: While the mode field is nonzero and both release bits are 1, the count goes up by one each clock, and the low word carries into the high word.
- R3: Release word 0x24 keeps only bits [1:0]. Bit 0 gates the low count word and bit 1 gates the high count word. A half whose bit is 0 reads 0 from the next clock on, ignores writes and does not count.
- R4: When counting and the count equals the period, the count is 0 on the next clock and status bit 1 of word 0x44 is set.
- R5: In repeating mode (control bits [7:6] = 10) counting resumes from 0, so a period value P gives a match every P+1 clocks.
- R6: In single-shot mode (control bits [7:6] = 01) the hardware clears bits [7:6] to 00 on the clock after the match, and the count then stays at 0.
- R7: Writing control word 0x20 with bits [7:6] = 00 stops the count from the next clock on. All 32 bits written to the control word are kept and read back.
- R8: A write to count word 0x10 (low) or 0x14 (high) takes effect on the next clock and overrides that clock's increment or wrap. The write is accepted whether or not the timer is running.
- R9: Bit 0 of word 0x44 is the interrupt enable, and `irq_o` is 1 exactly when the status bit and the enable are both 1. Writing 1 to bit 1 clears the status. Writing 0 to bit 1 leaves the status unchanged.
- R10: The period is built from word 0x18 (bits 31:0) and word 0x1C (bits 63:32). Both words read back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the register word |
| we_i | input | 1 | Write strobe, applied on the rising clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level interrupt: status qualified by enable |

## Verification
Several rules are checked on every cycle. A running count that has not hit the period advances by exactly one. A match wraps the count to zero and sets the status. A single-shot match clears the mode field. A stopped timer holds its count. A gated low half stays at zero. A write-one clear drops the interrupt. Other behaviour can only be shown by the bench's scenarios: the exact P+1 repeat interval, the low-to-high carry, the retention of the non-mode control bits, the override of a running count by a write, and the sticky status surviving a write of zero.

// File: rtl/evt_timer_pkg.sv
`timescale 1ns/1ps
package evt_timer_pkg;
  localparam int unsigned OFF_CNT0    = 'h10;
  localparam int unsigned OFF_PRD0    = 'h18;
  localparam int unsigned OFF_CTRL    = 'h20;
  localparam int unsigned OFF_GCTL    = 'h24;
  localparam int unsigned OFF_IRQ     = 'h44;
  localparam int unsigned WORD_STRIDE = 4;
  localparam int unsigned MODE_LSB    = 6;
  localparam int unsigned IRQ_EN_BIT  = 0;
  localparam int unsigned IRQ_ST_BIT  = 1;

  typedef enum logic [1:0] {
    MODE_OFF      = 2'b00,
    MODE_ONESHOT  = 2'b01,
    MODE_PERIODIC = 2'b10,
    MODE_RSVD     = 2'b11
  } mode_e;
endpackage

// File: rtl/evt_timer_regs.sv
`timescale 1ns/1ps
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_HALF = 2,
  localparam int unsigned CNT_W   = DATA_W * NUM_HALF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                oneshot_done_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic                stat_i,
  output logic [CNT_W-1:0]    prd_o,
  output mode_e               mode_o,
  output logic [NUM_HALF-1:0] gctl_o,
  output logic                ien_o,
  output logic [NUM_HALF-1:0] cnt_wr_o,
  output logic                stat_clr_o,
  output logic [DATA_W-1:0]   rdata_o
);
  logic [DATA_W-1:0]   ctrl_q;
  logic [NUM_HALF-1:0] gctl_q;
  logic                ien_q;
  logic [CNT_W-1:0]    prd_q;
  logic                wr_ctrl, wr_gctl, wr_irq;

  assign wr_ctrl = we_i && (addr_i == ADDR_W'(OFF_CTRL));
  assign wr_gctl = we_i && (addr_i == ADDR_W'(OFF_GCTL));
  assign wr_irq  = we_i && (addr_i == ADDR_W'(OFF_IRQ));

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    logic wr_prd;
    assign wr_prd      = we_i && (addr_i == ADDR_W'(OFF_PRD0 + WORD_STRIDE * h));
    assign cnt_wr_o[h] = we_i && (addr_i == ADDR_W'(OFF_CNT0 + WORD_STRIDE * h));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     prd_q[h*DATA_W +: DATA_W] <= '0;
      else if (wr_prd) prd_q[h*DATA_W +: DATA_W] <= wdata_i;
    end
  end

  // software write wins over the single-shot self clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             ctrl_q <= '0;
    else if (wr_ctrl)        ctrl_q <= wdata_i;
    else if (oneshot_done_i) ctrl_q[MODE_LSB +: 2] <= 2'b00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gctl_q <= '0;
      ien_q  <= 1'b0;
    end else begin
      if (wr_gctl) gctl_q <= wdata_i[NUM_HALF-1:0];
      if (wr_irq)  ien_q  <= wdata_i[IRQ_EN_BIT];
    end
  end

  assign stat_clr_o = wr_irq && wdata_i[IRQ_ST_BIT];
  assign prd_o      = prd_q;
  assign mode_o     = mode_e'(ctrl_q[MODE_LSB +: 2]);
  assign gctl_o     = gctl_q;
  assign ien_o      = ien_q;

  always_comb begin
    rdata_o = '0;
    for (int h = 0; h < NUM_HALF; h++) begin
      if (addr_i == ADDR_W'(OFF_CNT0 + WORD_STRIDE * h)) rdata_o = cnt_i[h*DATA_W +: DATA_W];
      if (addr_i == ADDR_W'(OFF_PRD0 + WORD_STRIDE * h)) rdata_o = prd_q[h*DATA_W +: DATA_W];
    end
    if (addr_i == ADDR_W'(OFF_CTRL)) rdata_o = ctrl_q;
    if (addr_i == ADDR_W'(OFF_GCTL)) rdata_o = DATA_W'(gctl_q);
    if (addr_i == ADDR_W'(OFF_IRQ)) begin
      rdata_o[IRQ_EN_BIT] = ien_q;
      rdata_o[IRQ_ST_BIT] = stat_i;
    end
  end
endmodule

// File: rtl/evt_timer_cnt.sv
`timescale 1ns/1ps
module evt_timer_cnt #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_HALF = 2,
  localparam int unsigned CNT_W   = DATA_W * NUM_HALF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                wrap_i,
  input  logic [NUM_HALF-1:0] rel_i,
  input  logic [NUM_HALF-1:0] wr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [CNT_W-1:0]    cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + CNT_W'(1);

  // per half: release gate > software write > wrap > increment
  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q[h*DATA_W +: DATA_W] <= '0;
      else if (!rel_i[h]) cnt_q[h*DATA_W +: DATA_W] <= '0;
      else if (wr_i[h])   cnt_q[h*DATA_W +: DATA_W] <= wdata_i;
      else if (wrap_i)    cnt_q[h*DATA_W +: DATA_W] <= '0;
      else if (run_i)     cnt_q[h*DATA_W +: DATA_W] <= cnt_inc[h*DATA_W +: DATA_W];
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/evt_timer_irq.sv
`timescale 1ns/1ps
module evt_timer_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic stat_o,
  output logic irq_o
);
  logic stat_q;

  // a match in the same cycle as a clear keeps the flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stat_q <= 1'b0;
    else if (set_i) stat_q <= 1'b1;
    else if (clr_i) stat_q <= 1'b0;
  end

  assign stat_o = stat_q;
  assign irq_o  = stat_q & en_i;
endmodule

// File: rtl/evt_timer64.sv
`timescale 1ns/1ps
module evt_timer64
  import evt_timer_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_HALF = 2,
  localparam int unsigned CNT_W   = DATA_W * NUM_HALF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W-1:0]    prd_q;
  mode_e               mode_q;
  logic [NUM_HALF-1:0] gctl_q;
  logic [NUM_HALF-1:0] cnt_wr;
  logic                ien_q, stat_q, stat_clr;
  logic                run, match, oneshot_done;

  assign run          = (mode_q != MODE_OFF) && (&gctl_q);
  assign match        = run && (cnt_q == prd_q);
  assign oneshot_done = match && (mode_q == MODE_ONESHOT);

  evt_timer_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_HALF(NUM_HALF)
  ) u_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .addr_i         (addr_i),
    .we_i           (we_i),
    .wdata_i        (wdata_i),
    .oneshot_done_i (oneshot_done),
    .cnt_i          (cnt_q),
    .stat_i         (stat_q),
    .prd_o          (prd_q),
    .mode_o         (mode_q),
    .gctl_o         (gctl_q),
    .ien_o          (ien_q),
    .cnt_wr_o       (cnt_wr),
    .stat_clr_o     (stat_clr),
    .rdata_o        (rdata_o)
  );

  evt_timer_cnt #(
    .DATA_W(DATA_W), .NUM_HALF(NUM_HALF)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .wrap_i  (match),
    .rel_i   (gctl_q),
    .wr_i    (cnt_wr),
    .wdata_i (wdata_i),
    .cnt_o   (cnt_q)
  );

  evt_timer_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (match),
    .clr_i  (stat_clr),
    .en_i   (ien_q),
    .stat_o (stat_q),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/evt_timer64_chk.sv
`timescale 1ns/1ps
module evt_timer64_chk
  import evt_timer_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_HALF = 2,
  localparam int unsigned CNT_W   = DATA_W * NUM_HALF
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                we_i,
  input logic                wst_i,
  input logic                irq_i,
  input logic [CNT_W-1:0]    cnt_i,
  input logic [CNT_W-1:0]    prd_i,
  input mode_e               mode_i,
  input logic [NUM_HALF-1:0] gctl_i,
  input logic                stat_i
);
  logic run, hit, cnt_wr, ctrl_wr, irq_wr;

  assign run     = (mode_i != MODE_OFF) && (&gctl_i);
  assign hit     = run && (cnt_i == prd_i);
  assign cnt_wr  = we_i && (addr_i >= ADDR_W'(OFF_CNT0))
                        && (addr_i < ADDR_W'(OFF_CNT0 + WORD_STRIDE * NUM_HALF));
  assign ctrl_wr = we_i && (addr_i == ADDR_W'(OFF_CTRL));
  assign irq_wr  = we_i && (addr_i == ADDR_W'(OFF_IRQ));

  a_r2_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !hit && !cnt_wr) |=> (cnt_i == $past(cnt_i) + CNT_W'(1)));

  a_r3_low_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(gctl_i[0]) |-> (cnt_i[DATA_W-1:0] == '0));

  a_r4_wrap_sets_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !cnt_wr) |=> ((cnt_i == '0) && stat_i));

  a_r6_oneshot_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && (mode_i == MODE_ONESHOT) && !ctrl_wr) |=> (mode_i == MODE_OFF));

  a_r7_off_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == MODE_OFF) && (&gctl_i) && !cnt_wr) |=> $stable(cnt_i));

  a_r9_w1c_drops_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_wr && wst_i && !hit) |=> !irq_i);
endmodule

bind evt_timer64 evt_timer64_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_HALF(NUM_HALF)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .we_i   (we_i),
  .wst_i  (wdata_i[1]),
  .irq_i  (irq_o),
  .cnt_i  (cnt_q),
  .prd_i  (prd_q),
  .mode_i (mode_q),
  .gctl_i (gctl_q),
  .stat_i (stat_q)
);

// File: tb/evt_timer64_test.sv
`timescale 1ns/1ps
module evt_timer64_test;
  localparam logic [7:0] A_CLO = 8'h10, A_CHI = 8'h14, A_PLO = 8'h18, A_PHI = 8'h1C;
  localparam logic [7:0] A_CTL = 8'h20, A_GCT = 8'h24, A_IRQ = 8'h44;

  typedef struct packed {
    logic       we;
    logic [7:0] addr;
    logic [31:0] data;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, A_CLO, 32'h0, 4'd1},            // R1 reset values
    '{1'b0, A_CHI, 32'h0, 4'd1},
    '{1'b0, A_PLO, 32'h0, 4'd1},
    '{1'b0, A_PHI, 32'h0, 4'd1},
    '{1'b0, A_CTL, 32'h0, 4'd1},
    '{1'b0, A_GCT, 32'h0, 4'd1},
    '{1'b0, A_IRQ, 32'h0, 4'd1},
    '{1'b1, A_PLO, 32'hDEADBEEF, 4'd10},    // R10 period words
    '{1'b1, A_PHI, 32'h01234567, 4'd10},
    '{1'b0, A_PLO, 32'hDEADBEEF, 4'd10},
    '{1'b0, A_PHI, 32'h01234567, 4'd10},
    '{1'b1, A_CTL, 32'h12345633, 4'd7},     // R7 all bits kept
    '{1'b0, A_CTL, 32'h12345633, 4'd7},
    '{1'b1, A_GCT, 32'hFFFFFFFC, 4'd3},     // R3 only bits 1:0 stored
    '{1'b0, A_GCT, 32'h0, 4'd3},
    '{1'b1, A_IRQ, 32'h00000001, 4'd9},     // R9 enable bit
    '{1'b0, A_IRQ, 32'h00000001, 4'd9},
    '{1'b1, A_CLO, 32'h00000055, 4'd3},     // R3 held half ignores write
    '{1'b0, A_CLO, 32'h0, 4'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_timer64 uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a; we = 1'b0;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    #1;
    check(tag, {31'b0, irq}, {31'b0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_irq(1'b0, "R1 irq in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_irq(1'b0, "R1 irq after reset");

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) wr(VECS[i].addr, VECS[i].data);
      else rd(VECS[i].addr, VECS[i].data, $sformatf("R%0d table entry %0d", VECS[i].req, i));
    end
    wr(A_CTL, 32'h0);

    // R2 carry from low into high word
    wr(A_GCT, 32'h3);
    wr(A_CLO, 32'hFFFFFFFE);
    wr(A_CHI, 32'h0);
    rd(A_CLO, 32'hFFFFFFFE, "R8 load while stopped");
    wr(A_CTL, 32'h80);
    rd(A_CLO, 32'hFFFFFFFE, "R2 first count cycle");
    @(negedge clk);
    rd(A_CLO, 32'hFFFFFFFF, "R2 increment");
    @(negedge clk);
    rd(A_CLO, 32'h0, "R2 low wraps");
    rd(A_CHI, 32'h1, "R2 carry into high");

    // R7 stop keeps count and other control bits
    wr(A_CTL, 32'h33);
    rd(A_CLO, 32'h2, "R7 stop immediate");
    repeat (3) @(negedge clk);
    rd(A_CLO, 32'h2, "R7 count frozen");
    rd(A_CTL, 32'h33, "R7 control bits kept");

    // R4 R5 repeating, period 3
    wr(A_CLO, 32'h0);
    wr(A_CHI, 32'h0);
    wr(A_PLO, 32'h3);
    wr(A_PHI, 32'h0);
    wr(A_IRQ, 32'h3);
    wr(A_CTL, 32'h80);
    for (int k = 0; k < 9; k++) begin
      rd(A_CLO, 32'(k % 4), $sformatf("R5 periodic count step %0d", k));
      check($sformatf("R4 irq step %0d", k), {31'b0, irq}, {31'b0, k >= 4});
      if (k < 8) @(negedge clk);
    end

    // R9 write-one clear and enable gating
    wr(A_IRQ, 32'h3);
    chk_irq(1'b0, "R9 cleared");
    rd(A_IRQ, 32'h1, "R9 status cleared, enable kept");
    @(negedge clk);
    rd(A_CLO, 32'h3, "R5 reach period");
    @(negedge clk);
    chk_irq(1'b1, "R9 irq after next match");
    wr(A_IRQ, 32'h0);
    chk_irq(1'b0, "R9 enable off masks irq");
    rd(A_IRQ, 32'h2, "R9 zero write keeps status");

    // R6 single shot, period 2
    wr(A_CTL, 32'h0);
    wr(A_CLO, 32'h0);
    wr(A_CHI, 32'h0);
    wr(A_PLO, 32'h2);
    wr(A_IRQ, 32'h2);
    rd(A_IRQ, 32'h0, "R9 status cleared while stopped");
    wr(A_CTL, 32'h40);
    for (int k = 0; k < 4; k++) begin
      rd(A_CLO, 32'(k % 3), $sformatf("R6 oneshot step %0d", k));
      if (k < 3) @(negedge clk);
    end
    rd(A_CTL, 32'h0, "R6 mode self cleared");
    rd(A_IRQ, 32'h2, "R4 status after oneshot match");
    repeat (3) @(negedge clk);
    rd(A_CLO, 32'h0, "R6 stays at zero");

    // R8 write overrides a running count
    wr(A_PLO, 32'd100);
    wr(A_CTL, 32'h80);
    @(negedge clk);
    wr(A_CLO, 32'd50);
    rd(A_CLO, 32'd50, "R8 override");
    @(negedge clk);
    rd(A_CLO, 32'd51, "R8 counts on");

    // R3 release gating of the low half
    wr(A_GCT, 32'h2);
    rd(A_CLO, 32'd53, "R3 gate takes one clock");
    @(negedge clk);
    rd(A_CLO, 32'h0, "R3 low held");
    repeat (2) @(negedge clk);
    rd(A_CLO, 32'h0, "R3 no counting");
    wr(A_CLO, 32'h7);
    rd(A_CLO, 32'h0, "R3 write ignored");
    wr(A_GCT, 32'h3);
    rd(A_CLO, 32'h0, "R3 released");
    @(negedge clk);
    rd(A_CLO, 32'h1, "R3 resumes");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule